// File: doc/BRIEF.md
# Digital Receiver Power-Save Controller

This block decides whether a digital video source is present and manages the power of the digital link receiver from that decision. A raw signal-detect line from the receiver is synchronised, sampled once per millisecond tick and debounced. The debounced level is reported as the presence flag. Two active-low power-down outputs are driven from this flag, from the front power switch and from the selected input source. One output gates the receiver's output buffers. The other gates the receiver's internal logic.

In normal operation the receiver logic stays on and presence is re-evaluated on every tick. When a power-save request is active, the internal logic is woken only for a short window in each long period. Detect samples are taken only inside those windows, so a noisy detect line while the receiver sleeps cannot cause a false wake-up. A clock divider produces the millisecond tick. The period and window lengths are counted in ticks.

Top module: `rx_power_ctl`

## Requirements
- R1: While reset is asserted, `bufPdN`, `corePdN` and `presentOut` are all 0.
- R2: `presentOut` is 1 when the debounced detect level is high (input present) and 0 when it is low (no input).
- R3: The debounced level takes a new value only after STABLE_SAMPLES consecutive tick samples of the synchronised detect line all show that value. One tick lasts CLK_PER_TICK clocks, and the synchronizer adds two clocks of delay. A detect pulse shorter than (STABLE_SAMPLES-1)*CLK_PER_TICK clocks is ignored.
- R4: `bufPdN` is 1 only when the power switch is on, `srcSel` is 2'b00 (digital DVI) and `presentOut` is 1; otherwise it is 0. The codes 2'b01 (analog DVI), 2'b10 (D-Sub) and 2'b11 count as analog. `bufPdN` follows its inputs one clock later.
- R5: With the power switch off, `corePdN` is 0 one clock later, whatever `saveReq` is.
- R6: With the power switch on and `saveReq` low, `corePdN` is 1 one clock later.
- R7: When power save begins (switch on, `saveReq` rises), `corePdN` is high from the next clock edge for HIGH_TICKS*CLK_PER_TICK clocks. It is then low for the rest of a PERIOD_TICKS*CLK_PER_TICK clock period, and this pattern repeats. Each new entry into power save restarts the pattern at its high window.
- R8: When `saveReq` falls with the power switch on, `corePdN` is 1 after the next clock edge.
- R9: During power save, detect samples are taken only while `corePdN` is high. At other times the debounced level and the sample count are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| detRaw | input | 1 | Raw signal-detect line from the receiver |
| pwrOn | input | 1 | Front power switch level, 1 = on |
| srcSel | input | 2 | Selected source: 00 digital DVI, 01 analog DVI, 10 D-Sub, 11 analog |
| saveReq | input | 1 | Power-save request |
| presentOut | output | 1 | Debounced presence flag |
| bufPdN | output | 1 | Receiver output-buffer power-down, active low |
| corePdN | output | 1 | Receiver internal-logic power-down, active low |

## Verification
The checker enforces the following on every clock:
- `corePdN` is forced low when the switch is off and held high outside power save.
- `corePdN` opens a high window on entry to power save and goes high on exit.
- `bufPdN` stays low when the switch is off or an analog source is selected, and never rises without presence.
- The presence flag is frozen when a sleep phase of power save is sampled.

Some behaviours need the bench's timed scenarios:
- the latency window of the debounce and the rejection of short glitches;
- the exact length of the pulse period and of its high window;
- the fact that a pending detect is accepted only after samples from two separate wake windows.

// File: rtl/rxpwr_pkg.sv
package rxpwr_pkg;

  typedef enum logic [1:0] {
    SRC_DVI_D = 2'b00,
    SRC_DVI_A = 2'b01,
    SRC_DSUB  = 2'b10,
    SRC_RSVD  = 2'b11
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic powered;   // registered power switch level
    logic sampleEn;  // take one detect sample this clock
  } pwrStrobe_t;

endpackage

// File: rtl/rxpwr_ctrl.sv
module rxpwr_ctrl
  import rxpwr_pkg::*;
#(
  parameter int CLK_PER_TICK = 250000,
  parameter int PERIOD_TICKS = 500,
  parameter int HIGH_TICKS   = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOn,
  input  logic       saveReq,
  output pwrStrobe_t strb,
  output logic       corePdN
);

  localparam int DIV_W = $clog2(CLK_PER_TICK + 1);
  localparam int PH_W  = $clog2(PERIOD_TICKS + 1);

  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic pwrOnQ, saveQ;
  logic tick, saveNow, restart, pulseHigh, coreOn;

  assign tick      = (divCnt == DIV_W'(CLK_PER_TICK - 1));
  assign saveNow   = pwrOn & saveReq;
  assign restart   = saveNow & ~saveQ;
  assign pulseHigh = (phaseCnt < PH_W'(HIGH_TICKS));
  assign coreOn    = pwrOnQ & (~saveQ | pulseHigh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      phaseCnt <= '0;
      pwrOnQ   <= 1'b0;
      saveQ    <= 1'b0;
    end else begin
      pwrOnQ <= pwrOn;
      saveQ  <= saveNow;
      if (restart || tick) divCnt <= '0;
      else                 divCnt <= divCnt + 1'b1;
      if (!saveNow || restart)
        phaseCnt <= '0;
      else if (tick)
        phaseCnt <= (phaseCnt == PH_W'(PERIOD_TICKS - 1)) ? '0 : phaseCnt + 1'b1;
    end
  end

  assign strb.powered  = pwrOnQ;
  assign strb.sampleEn = tick & (~saveQ | coreOn);
  assign corePdN       = coreOn;

endmodule

// File: rtl/rxpwr_dpath.sv
module rxpwr_dpath
  import rxpwr_pkg::*;
#(
  parameter int STABLE_SAMPLES = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       detRaw,
  input  logic [1:0] srcSel,
  input  pwrStrobe_t strb,
  output logic       presentOut,
  output logic       bufPdN
);

  localparam int RUN_W = $clog2(STABLE_SAMPLES + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [RUN_W-1:0]       runCnt;
  logic                   detFilt;
  srcSel_e                srcQ;
  logic                   detSync;

  assign detSync = syncReg[SYNC_STAGES-1];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncReg[g] <= 1'b0;
        else       syncReg[g] <= (g == 0) ? detRaw : syncReg[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ    <= SRC_DSUB;
      runCnt  <= '0;
      detFilt <= 1'b0;
    end else begin
      srcQ <= srcSel_e'(srcSel);
      if (strb.sampleEn) begin
        if (detSync == detFilt) begin
          runCnt <= '0;
        end else if (runCnt == RUN_W'(STABLE_SAMPLES - 1)) begin
          detFilt <= detSync;
          runCnt  <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end
  end

  assign presentOut = detFilt;
  assign bufPdN     = strb.powered & (srcQ == SRC_DVI_D) & detFilt;

endmodule

// File: rtl/rx_power_ctl.sv
module rx_power_ctl
  import rxpwr_pkg::*;
#(
  parameter int CLK_PER_TICK   = 250000,
  parameter int PERIOD_TICKS   = 500,
  parameter int HIGH_TICKS     = 50,
  parameter int STABLE_SAMPLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       detRaw,
  input  logic       pwrOn,
  input  logic [1:0] srcSel,
  input  logic       saveReq,
  output logic       presentOut,
  output logic       bufPdN,
  output logic       corePdN
);

  pwrStrobe_t strb;

  rxpwr_ctrl #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .PERIOD_TICKS(PERIOD_TICKS),
    .HIGH_TICKS  (HIGH_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pwrOn  (pwrOn),
    .saveReq(saveReq),
    .strb   (strb),
    .corePdN(corePdN)
  );

  rxpwr_dpath #(
    .STABLE_SAMPLES(STABLE_SAMPLES),
    .SYNC_STAGES   (2)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .detRaw    (detRaw),
    .srcSel    (srcSel),
    .strb      (strb),
    .presentOut(presentOut),
    .bufPdN    (bufPdN)
  );

endmodule

// File: rtl/rxpwr_chk.sv
module rxpwr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrOn,
  input logic [1:0] srcSel,
  input logic       saveReq,
  input logic       presentOut,
  input logic       bufPdN,
  input logic       corePdN
);

  // R5
  core_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> !corePdN);

  // R6
  core_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOn && !saveReq) |=> corePdN);

  // R7
  save_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOn && $rose(saveReq)) |=> corePdN);

  // R8
  save_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOn && $fell(saveReq)) |=> corePdN);

  // R4
  buf_nopwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> !bufPdN);

  // R4
  buf_analog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != 2'b00) |=> !bufPdN);

  // R4
  buf_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufPdN |-> presentOut);

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrOn && saveReq) && !corePdN) |=> $stable(presentOut));

endmodule

bind rx_power_ctl rxpwr_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pwrOn     (pwrOn),
  .srcSel    (srcSel),
  .saveReq   (saveReq),
  .presentOut(presentOut),
  .bufPdN    (bufPdN),
  .corePdN   (corePdN)
);

// File: tb/rx_power_ctl_tb.sv
`timescale 1ns/1ps
module rx_power_ctl_tb;

  localparam int C  = 4;
  localparam int P  = 10;
  localparam int H  = 3;
  localparam int S  = 4;
  localparam int PC = P * C;
  localparam int HC = H * C;

  logic clk = 1'b0;
  logic rstN, detRaw, pwrOn, saveReq;
  logic [1:0] srcSel;
  logic presentOut, bufPdN, corePdN;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rx_power_ctl #(
    .CLK_PER_TICK(C), .PERIOD_TICKS(P), .HIGH_TICKS(H), .STABLE_SAMPLES(S)
  ) u_dut (
    .clk(clk), .rstN(rstN), .detRaw(detRaw), .pwrOn(pwrOn), .srcSel(srcSel),
    .saveReq(saveReq), .presentOut(presentOut), .bufPdN(bufPdN), .corePdN(corePdN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Measure debounce latency of a detect change (R3)
  task automatic latency(input logic lvl);
    int n = 0;
    detRaw = lvl;
    while (presentOut !== lvl && n < 60) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (n < (S-1)*C + 3 || n > S*C + 2) begin
      errors++;
      $display("FAIL R3 latency actual=%0d expected=%0d..%0d", n, (S-1)*C + 3, S*C + 2);
    end
    check("R2 presence level", presentOut, lvl);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; detRaw = 0; pwrOn = 1; srcSel = 2'b00; saveReq = 0;
    waitN(5);
    check("R1 bufPdN in reset", bufPdN, 1'b0);
    check("R1 corePdN in reset", corePdN, 1'b0);
    check("R1 presentOut in reset", presentOut, 1'b0);
    rstN = 1;
    waitN(1);
    check("R6 core on after reset", corePdN, 1'b1);

    latency(1'b1);
    check("R4 buffers enabled", bufPdN, 1'b1);
    latency(1'b0);

    // Glitch shorter than S-1 ticks (R3)
    detRaw = 1;
    waitN((S-1)*C);
    detRaw = 0;
    for (int i = 0; i < 3*S*C; i++) begin
      @(negedge clk);
      if (presentOut !== 1'b0) begin
        check("R3 glitch ignored", presentOut, 1'b0);
        break;
      end
    end
    check("R3 glitch ignored", presentOut, 1'b0);

    // Sweep power, source, presence, save request (R4 R5 R6)
    for (int f = 0; f < 2; f++) begin
      pwrOn = 1; saveReq = 0; detRaw = f[0];
      waitN(3*S*C);
      for (int p = 0; p < 2; p++) begin
        for (int s = 0; s < 4; s++) begin
          for (int sv = 0; sv < 2; sv++) begin
            if (p == 1 && sv == 1) continue;
            pwrOn = p[0]; srcSel = s[1:0]; saveReq = sv[0];
            waitN(2);
            check("R4 buffer gate", bufPdN, (p == 1 && s == 0 && f == 1));
            check(p == 1 ? "R6 core held on" : "R5 core held off", corePdN, p[0]);
            check("R2 presence", presentOut, f[0]);
          end
        end
      end
    end

    // Power-save pulse pattern and gated sampling (R7 R9)
    pwrOn = 1; srcSel = 2'b00; saveReq = 0; detRaw = 0;
    waitN(3*S*C);
    saveReq = 1; detRaw = 1;
    for (int n = 0; n <= 2*PC + HC + 2; n++) begin
      @(negedge clk);
      check("R7 pulse pattern", corePdN, ((n % PC) < HC));
      if (n == (P+1)*C - 1) check("R9 held while asleep", presentOut, 1'b0);
      if (n == (P+1)*C)     check("R9 accepted in next window", presentOut, 1'b1);
    end

    // Leave power save in a low phase (R8)
    check("R7 low phase before exit", corePdN, 1'b0);
    saveReq = 0;
    @(negedge clk);
    check("R8 high after exit", corePdN, 1'b1);
    waitN(3);
    check("R6 stays high", corePdN, 1'b1);

    // Re-entry restarts at high window (R7)
    saveReq = 1;
    @(negedge clk);
    check("R7 restart high", corePdN, 1'b1);
    waitN(HC);
    check("R7 restart low after window", corePdN, 1'b0);

    // Power off during save (R5)
    pwrOn = 0;
    waitN(2);
    check("R5 off during save", corePdN, 1'b0);
    check("R4 off during save", bufPdN, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule